// File: doc/BRIEF.md
# Variable-Size Rotating Register Window File

This block holds a circular file of 64-bit registers, and each procedure sees part of that file as its own window. Software sets the window length at run time, in quad units of two registers each. Register numbers are always counted from the window base, and the first register of every window is number 0. Inside the current window, software can also mark an outgoing area by its start and length, both given relative to the window base. On a call, the callee's window begins at an offset that is supplied with the call. The caller's register at that offset then becomes the callee's register 0, so arguments are handed over without any copying.

The file holds a fixed number of quads (`QUADS`, which must be a power of two, 64 by default). When a call or a resize would need more space than the file has, the oldest resident registers spill automatically to a procedure stack in memory. This stack grows toward higher addresses from a 4 KiB-aligned base. A return refills missing caller registers from the top of the stack downward. A flush command pushes every register below the current window out to memory.

A signed hardware top-of-stack index counts, in quads, the registers resident below the window base. While a refill is pending this index is negative. The block does not keep the caller's window size and offset. It presents them on `link_out` after a call, and software hands them back with the return command.

Top module: `rwin_regfile`

## Requirements
- R1: After reset no spill or fill is pending, `hw_tos`, `stk_ofs` and `win_base` are 0, `mem_req` is 0, and the window size is 0, so any register access raises `err`.
- R2: A read or write uses register number `idx` of the current window, which maps to physical register (`win_base` + `idx`) mod 2·`QUADS`. A read returns the value last written there. Reads are combinational and writes take effect at the clock edge.
- R3: Any access with `idx` at or above twice the window size, or at or above twice the outgoing size when `*_out`=1, raises `err` in the same cycle. Such a read returns 0 and such a write leaves the file unchanged.
- R4: Opcode 4 (set outgoing, `cmd_a`=start, `cmd_b`=length, in quads) makes outgoing register i the window register 2·start+i. It raises `err` and is ignored if start+length exceeds the window size.
- R5: Opcode 1 (call, `cmd_a`=offset, `cmd_b`=new size) moves the window base by 2·offset registers, so callee register 0 is caller register 2·offset. It sets `link_out` = {offset, caller size}, each `QW` bits with the offset in the upper half, and it clears the outgoing area.
- R6: Opcode 2 (return, `cmd_a`=offset, `cmd_b`=caller size, taken from `link_out`) restores the caller's window base and size. The caller's registers then read back their earlier values, except those the callee wrote through the shared area.
- R7: When resident registers below the base plus the window exceed 2·`QUADS`, the lowest resident registers are written one at a time to `stk_base`+8·k, with k rising, until they fit. `stk_ofs` ends at 8 times the number of words on the stack.
- R8: After a return whose caller registers are not resident, words are read from the stack top downward into the missing registers until none is missing. `stk_ofs` falls by 8 per word.
- R9: `hw_tos` is a 12-bit two's-complement count of quads resident below the window base. It is negative while a return's refill is pending.
- R10: Opcode 5 (flush) spills every register below the current window, after which `hw_tos` is 0.
- R11: A memory word moves when `mem_req` and `mem_ack` are both 1, with `mem_we`=1 for a spill. While `mem_ack` is 0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady.
- R12: `busy` is 1 while a spill or fill is pending, and commands given then are ignored. An illegal command raises `err` and changes nothing. A call is illegal if its offset exceeds the window size or its new size is 0 or above `QUADS`. Opcode 3 (set size, `cmd_b`) is illegal if the size is 0, above `QUADS`, or smaller than the outgoing area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read access strobe |
| rd_out | input | 1 | Read index is relative to the outgoing area |
| rd_idx | input | IW | Read register number |
| rd_data | output | 64 | Read data, 0 when out of range |
| wr_en | input | 1 | Write strobe, ignored while busy |
| wr_out | input | 1 | Write index is relative to the outgoing area |
| wr_idx | input | IW | Write register number |
| wr_data | input | 64 | Write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 1 call, 2 return, 3 set size, 4 set outgoing, 5 flush |
| cmd_a | input | QW | Offset or outgoing start, in quads |
| cmd_b | input | QW | Size or outgoing length, in quads |
| link_out | output | 2·QW | {call offset, caller size} captured at the last call |
| busy | output | 1 | Spill or fill in progress |
| err | output | 1 | Illegal access or command this cycle |
| win_base | output | IW | Physical index of window register 0 |
| hw_tos | output | 12 | Signed quad count resident below the base |
| stk_base | input | AW | Procedure stack base, 4 KiB aligned |
| stk_ofs | output | AW | Byte offset of the stack top |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 spill write, 0 fill read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 64 | Spill data |
| mem_ack | input | 1 | Memory ready; the word moves when it is 1 while requested |
| mem_rdata | input | 64 | Fill data, valid with `mem_ack` |

## Verification
Assertions check every cycle that a memory request holds its address, direction and data while it waits, so back-pressure never corrupts a transfer. They also check that a spill never goes past the window base, that a fill never pops an empty stack, and that a command given while busy leaves the window size untouched. The bench's scenarios are the only way to show end-to-end data movement. They check argument passing through the shared area, the exact words and addresses spilled and refilled around the circular wrap, the negative index during a refill, and the flush leaving exactly the stack contents expected.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_CALL   = 3'd1,
    OP_RET    = 3'd2,
    OP_SETWIN = 3'd3,
    OP_SETROT = 3'd4,
    OP_FLUSH  = 3'd5
  } rwin_op_e;
endpackage

// File: rtl/rwin_xlate.sv
module rwin_xlate #(
  parameter int IW = 7
) (
  input  logic [IW-1:0] wb,
  input  logic [IW-1:0] wsz,
  input  logic [IW-1:0] rbase,
  input  logic [IW-1:0] rsize,
  input  logic          sel_out,
  input  logic [IW-1:0] idx,
  output logic [IW-1:0] phys,
  output logic          bad
);
  logic [IW-1:0] start;
  logic [IW:0]   limit;

  assign start = sel_out ? {rbase[IW-2:0], 1'b0} : '0;
  assign limit = sel_out ? {rsize, 1'b0} : {wsz, 1'b0};
  assign phys  = wb + start + idx;
  assign bad   = {1'b0, idx} >= limit;
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int NREG = 128,
  parameter int DW   = 64,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr0,
  output logic [DW-1:0] rdata0,
  input  logic [IW-1:0] raddr1,
  output logic [DW-1:0] rdata1
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rdata0 = regs[raddr0];
  assign rdata1 = regs[raddr1];
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int QUADS = 64,
  parameter int AW    = 32,
  localparam int NREG = 2 * QUADS,
  localparam int IW   = $clog2(NREG),
  localparam int RW   = IW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [IW-1:0] cmd_a,
  input  logic [IW-1:0] cmd_b,
  input  logic [AW-1:0] stk_base,
  input  logic          mem_ack,
  output logic [IW-1:0] wb,
  output logic [IW-1:0] wsz,
  output logic [IW-1:0] rbase,
  output logic [IW-1:0] rsize,
  output logic [2*IW-1:0] link_out,
  output logic          busy,
  output logic          cmd_err,
  output logic [11:0]   hw_tos,
  output logic [AW-1:0] stk_ofs,
  output logic [IW-1:0] spill_phys,
  output logic [IW-1:0] fill_phys,
  output logic          fill_we,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr
);
  localparam logic [IW-1:0]        QMAX   = IW'(QUADS);
  localparam logic signed [RW:0]   NREG_S = (RW+1)'(NREG);
  localparam logic [AW-4:0]        ONE    = 1;

  rwin_op_e op;
  logic signed [RW-1:0] resw;
  logic signed [RW-1:0] tq;
  logic signed [RW:0]   occ;
  logic [AW-4:0] ind, ind_sel;
  logic flushing, need_spill, need_fill, accept, cmd_ok, do_cmd, xfer;
  logic [IW-1:0] bottom;

  assign op         = rwin_op_e'(cmd_op);
  assign occ        = {resw[RW-1], resw} + $signed({2'b00, wsz, 1'b0});
  assign need_fill  = resw[RW-1];
  assign need_spill = (occ > NREG_S) || (flushing && !resw[RW-1] && resw != '0);
  assign busy       = need_spill | need_fill;
  assign accept     = cmd_valid && !busy;

  always_comb begin
    case (op)
      OP_CALL:   cmd_ok = cmd_a <= wsz && cmd_b != '0 && cmd_b <= QMAX;
      OP_RET:    cmd_ok = cmd_b != '0 && cmd_b <= QMAX && cmd_a <= cmd_b;
      OP_SETWIN: cmd_ok = cmd_b != '0 && cmd_b <= QMAX &&
                          ({1'b0, rbase} + {1'b0, rsize}) <= {1'b0, cmd_b};
      OP_SETROT: cmd_ok = ({1'b0, cmd_a} + {1'b0, cmd_b}) <= {1'b0, wsz};
      OP_FLUSH:  cmd_ok = 1'b1;
      default:   cmd_ok = 1'b0;
    endcase
  end

  assign cmd_err = accept && !cmd_ok;
  assign do_cmd  = accept && cmd_ok;

  assign bottom     = wb - resw[IW-1:0];
  assign spill_phys = bottom;
  assign fill_phys  = bottom - 1'b1;
  assign mem_req    = busy;
  assign mem_we     = need_spill;
  assign ind_sel    = need_spill ? ind : ind - ONE;
  assign mem_addr   = stk_base + {ind_sel, 3'b000};
  assign xfer       = mem_req && mem_ack;
  assign fill_we    = xfer && need_fill;
  assign stk_ofs    = {ind, 3'b000};
  assign tq         = resw >>> 1;
  assign hw_tos     = {{(12-RW){tq[RW-1]}}, tq};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb <= '0; wsz <= '0; rbase <= '0; rsize <= '0;
      resw <= '0; ind <= '0; flushing <= 1'b0; link_out <= '0;
    end else begin
      if (accept)     flushing <= (op == OP_FLUSH);
      else if (!busy) flushing <= 1'b0;
      if (xfer) begin
        if (need_spill) begin
          resw <= resw - RW'(1);
          ind  <= ind + ONE;
        end else begin
          resw <= resw + RW'(1);
          ind  <= ind - ONE;
        end
      end else if (do_cmd) begin
        case (op)
          OP_CALL: begin
            wb       <= wb + {cmd_a[IW-2:0], 1'b0};
            resw     <= resw + $signed({1'b0, cmd_a, 1'b0});
            wsz      <= cmd_b;
            rbase    <= '0;
            rsize    <= '0;
            link_out <= {cmd_a, wsz};
          end
          OP_RET: begin
            wb    <= wb - {cmd_a[IW-2:0], 1'b0};
            resw  <= resw - $signed({1'b0, cmd_a, 1'b0});
            wsz   <= cmd_b;
            rbase <= '0;
            rsize <= '0;
          end
          OP_SETWIN: wsz <= cmd_b;
          OP_SETROT: begin
            rbase <= cmd_a;
            rsize <= cmd_b;
          end
          default: ;
        endcase
      end
    end
  end

  // R7: a spill only takes registers that lie below the window base
  assert_spill_below_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (!resw[RW-1] && resw != '0));

  // R8: a refill never pops from an empty stack
  assert_fill_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> ind != '0);

  // R12: commands offered while busy leave the window untouched
  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> ($stable(wsz) && $stable(wb)));
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile #(
  parameter int QUADS = 64,
  parameter int AW    = 32,
  localparam int NREG = 2 * QUADS,
  localparam int IW   = $clog2(NREG),
  localparam int QW   = IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rd_out,
  input  logic [IW-1:0] rd_idx,
  output logic [63:0]   rd_data,
  input  logic          wr_en,
  input  logic          wr_out,
  input  logic [IW-1:0] wr_idx,
  input  logic [63:0]   wr_data,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [QW-1:0] cmd_a,
  input  logic [QW-1:0] cmd_b,
  output logic [2*QW-1:0] link_out,
  output logic          busy,
  output logic          err,
  output logic [IW-1:0] win_base,
  output logic [11:0]   hw_tos,
  input  logic [AW-1:0] stk_base,
  output logic [AW-1:0] stk_ofs,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [63:0]   mem_rdata
);
  logic [IW-1:0] wb, wsz, rbase, rsize, rd_phys, wr_phys, spill_phys, fill_phys, waddr;
  logic rd_bad, wr_bad, cmd_err, fill_we, st_we;
  logic [63:0] rdat0, rdat1, wdat;

  rwin_ctrl #(.QUADS(QUADS), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .stk_base(stk_base), .mem_ack(mem_ack),
    .wb(wb), .wsz(wsz), .rbase(rbase), .rsize(rsize), .link_out(link_out),
    .busy(busy), .cmd_err(cmd_err), .hw_tos(hw_tos), .stk_ofs(stk_ofs),
    .spill_phys(spill_phys), .fill_phys(fill_phys), .fill_we(fill_we),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr)
  );

  rwin_xlate #(.IW(IW)) u_rdx (
    .wb(wb), .wsz(wsz), .rbase(rbase), .rsize(rsize),
    .sel_out(rd_out), .idx(rd_idx), .phys(rd_phys), .bad(rd_bad)
  );

  rwin_xlate #(.IW(IW)) u_wrx (
    .wb(wb), .wsz(wsz), .rbase(rbase), .rsize(rsize),
    .sel_out(wr_out), .idx(wr_idx), .phys(wr_phys), .bad(wr_bad)
  );

  assign st_we = fill_we || (wr_en && !wr_bad && !busy);
  assign waddr = fill_we ? fill_phys : wr_phys;
  assign wdat  = fill_we ? mem_rdata : wr_data;

  rwin_store #(.NREG(NREG), .DW(64)) u_store (
    .clk(clk), .we(st_we), .waddr(waddr), .wdata(wdat),
    .raddr0(rd_phys), .rdata0(rdat0), .raddr1(spill_phys), .rdata1(rdat1)
  );

  assign rd_data   = (rd_en && !rd_bad) ? rdat0 : 64'd0;
  assign mem_wdata = rdat1;
  assign win_base  = wb;
  assign err       = cmd_err || (rd_en && rd_bad) || (wr_en && wr_bad);

  // R11: a waiting memory request keeps its address, direction and data
  assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
endmodule

// File: tb/sim_rwin_regfile.sv
`timescale 1ns/1ps
module sim_rwin_regfile;
  localparam logic [31:0] BASE = 32'h0001_0000;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_en = 0, rd_out = 0, wr_en = 0, wr_out = 0, cmd_valid = 0;
  logic [6:0] rd_idx = 0, wr_idx = 0, cmd_a = 0, cmd_b = 0;
  logic [2:0] cmd_op = 0;
  logic [63:0] rd_data, wr_data = 0, mem_wdata, mem_rdata;
  logic [13:0] link_out;
  logic busy, err, mem_req, mem_we, ack = 1'b0;
  logic [6:0] win_base;
  logic [11:0] hw_tos;
  logic [31:0] stk_ofs, mem_addr;
  int nchk = 0, nerr = 0, wptr = 0, ordbad = 0;
  logic [3:0] cyc = 0;
  logic [63:0] bmem [256];
  wire [7:0] midx = 8'((mem_addr - BASE) >> 3);

  always #2.5 clk = ~clk;

  rwin_regfile u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_out(rd_out), .rd_idx(rd_idx),
    .rd_data(rd_data), .wr_en(wr_en), .wr_out(wr_out), .wr_idx(wr_idx),
    .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_a(cmd_a),
    .cmd_b(cmd_b), .link_out(link_out), .busy(busy), .err(err),
    .win_base(win_base), .hw_tos(hw_tos), .stk_base(BASE), .stk_ofs(stk_ofs),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(ack), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = bmem[midx];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ack <= (cyc[1:0] != 2'b00);
    if (mem_req && ack) begin
      if (mem_we) begin
        if (mem_addr != BASE + 32'(wptr * 8)) ordbad++;
        bmem[midx] <= mem_wdata;
        wptr++;
      end else begin
        if (mem_addr != BASE + 32'((wptr - 1) * 8)) ordbad++;
        wptr--;
      end
    end
  end

  function automatic logic [63:0] pv(input int i);
    return 64'hA5A5_0000_0000_0000 | 64'(i);
  endfunction
  function automatic logic [63:0] qv(input int i);
    return 64'hB7B7_0000_0000_0000 | 64'(i);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [6:0] a, input logic [6:0] b);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic wr(input logic o, input int i, input logic [63:0] d, output logic e);
    @(negedge clk);
    wr_en = 1; wr_out = o; wr_idx = 7'(i); wr_data = d;
    #1 e = err;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic o, input int i, output logic [63:0] d, output logic e);
    @(negedge clk);
    rd_en = 1; rd_out = o; rd_idx = 7'(i);
    #1 d = rd_data; e = err;
    rd_en = 0;
  endtask

  task automatic t_reset();
    logic [63:0] d; logic e;
    check("R1 busy", 64'(busy), 0);
    check("R1 hw_tos", 64'(hw_tos), 0);
    check("R1 stk_ofs", 64'(stk_ofs), 0);
    check("R1 win_base", 64'(win_base), 0);
    check("R1 mem_req", 64'(mem_req), 0);
    rd(0, 0, d, e);
    check("R1 size zero err", 64'(e), 1);
  endtask

  task automatic t_window();
    logic [63:0] d; logic e;
    do_cmd(3'd3, 0, 8);
    for (int i = 0; i < 16; i++) wr(0, i, 64'h1000 + 64'(i), e);
    for (int i = 0; i < 16; i++) begin
      rd(0, i, d, e);
      check("R2 readback", d, 64'h1000 + 64'(i));
    end
  endtask

  task automatic t_range();
    logic [63:0] d; logic e;
    do_cmd(3'd3, 0, 9);
    wr(0, 16, 64'hAAAA, e);
    do_cmd(3'd3, 0, 8);
    wr(0, 16, 64'hBBBB, e);
    check("R3 write err", 64'(e), 1);
    rd(0, 16, d, e);
    check("R3 read err", 64'(e), 1);
    check("R3 read zero", d, 0);
    do_cmd(3'd3, 0, 9);
    rd(0, 16, d, e);
    check("R3 write discarded", d, 64'hAAAA);
    do_cmd(3'd3, 0, 8);
  endtask

  task automatic t_rot();
    logic [63:0] d; logic e;
    do_cmd(3'd4, 4, 2);
    rd(1, 0, d, e);
    check("R4 out0 is reg8", d, 64'h1008);
    rd(1, 3, d, e);
    check("R4 out3 is reg11", d, 64'h100B);
    rd(1, 4, d, e);
    check("R4 out limit err", 64'(e), 1);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd4; cmd_a = 6; cmd_b = 3;
    #1 check("R4 oversize err", 64'(err), 1);
    @(negedge clk); cmd_valid = 0;
    rd(1, 3, d, e);
    check("R4 oversize ignored", d, 64'h100B);
  endtask

  task automatic t_call_ret();
    logic [63:0] d; logic e;
    do_cmd(3'd1, 4, 6);
    check("R5 link", 64'(link_out), 64'({7'd4, 7'd8}));
    check("R5 base", 64'(win_base), 8);
    check("R9 tos after call", 64'(hw_tos), 4);
    rd(0, 0, d, e);
    check("R5 callee r0", d, 64'h1008);
    rd(1, 0, d, e);
    check("R5 outgoing cleared", 64'(e), 1);
    wr(0, 0, 64'hC0DE, e);
    do_cmd(3'd2, 4, 8);
    check("R6 base restored", 64'(win_base), 0);
    rd(0, 8, d, e);
    check("R6 shared reg", d, 64'hC0DE);
    rd(0, 3, d, e);
    check("R6 caller reg", d, 64'h1003);
    rd(0, 15, d, e);
    check("R6 size restored", 64'(e), 0);
  endtask

  task automatic t_spill_fill();
    logic [63:0] d; logic e; int bad;
    do_cmd(3'd3, 0, 40);
    for (int i = 0; i < 80; i++) wr(0, i, pv(i), e);
    do_cmd(3'd1, 36, 40);
    check("R12 busy on spill", 64'(busy), 1);
    do_cmd(3'd3, 0, 1);
    wait_idle();
    check("R7 stk_ofs", 64'(stk_ofs), 192);
    check("R9 tos after spill", 64'(hw_tos), 24);
    bad = 0;
    for (int k = 0; k < 24; k++) if (bmem[k] !== pv(k)) bad++;
    check("R7 spilled words", 64'(bad), 0);
    rd(0, 79, d, e);
    check("R12 busy cmd ignored", 64'(e), 0);
    rd(0, 0, d, e);
    check("R5 callee r0 wraps", d, pv(72));
    for (int i = 0; i < 80; i++) wr(0, i, qv(i), e);
    do_cmd(3'd2, 36, 40);
    check("R9 negative tos", 64'(hw_tos), 64'(12'hFF4));
    wait_idle();
    check("R8 stk_ofs", 64'(stk_ofs), 0);
    check("R9 tos zero", 64'(hw_tos), 0);
    bad = 0;
    for (int i = 0; i < 80; i++) begin
      rd(0, i, d, e);
      if (d !== ((i < 72) ? pv(i) : qv(i - 72))) bad++;
    end
    check("R8 refill values", 64'(bad), 0);
  endtask

  task automatic t_flush();
    logic [63:0] d; logic e; int bad;
    do_cmd(3'd1, 8, 4);
    check("R9 tos before flush", 64'(hw_tos), 8);
    do_cmd(3'd5, 0, 0);
    wait_idle();
    check("R10 tos zero", 64'(hw_tos), 0);
    check("R10 stk_ofs", 64'(stk_ofs), 128);
    bad = 0;
    for (int k = 0; k < 16; k++) if (bmem[k] !== pv(k)) bad++;
    check("R10 flushed words", 64'(bad), 0);
    do_cmd(3'd2, 8, 40);
    wait_idle();
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      rd(0, i, d, e);
      if (d !== pv(i)) bad++;
    end
    check("R8 refill after flush", 64'(bad), 0);
  endtask

  task automatic t_illegal();
    logic [63:0] d; logic e;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd1; cmd_a = 41; cmd_b = 4;
    #1 check("R12 bad call err", 64'(err), 1);
    @(negedge clk); cmd_valid = 0;
    check("R12 bad call ignored", 64'(win_base), 0);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd3; cmd_a = 0; cmd_b = 65;
    #1 check("R12 bad size err", 64'(err), 1);
    @(negedge clk); cmd_valid = 0;
    rd(0, 79, d, e);
    check("R12 size unchanged", 64'(e), 0);
    check("R11 stack order", 64'(ordbad), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_window();
    t_range();
    t_rot();
    t_call_ret();
    t_spill_fill();
    t_flush();
    t_illegal();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule